// File: doc/BRIEF.md
# Mode-Tagged Instruction Cache

This block is a two-way set-associative instruction cache that serves fetches from a processor front end and refills from a burst memory port. It is separate from any data cache, so a fetch never waits behind a data access. Each line holds four 32-bit words, each way holds 128 lines, and a one-bit least-recently-used marker per set picks the way to replace on a miss.

The lookup address comes from one of two places. When the physical-fetch control input is low, address translation is on and the cache indexes and tags with the virtual address. When it is high, the cache uses the physical address. Every tag also stores the user/supervisor mode of the fetch that filled it, so the same address fetched in the two modes occupies two lines. Refills always go to memory with the physical address. Memory returns the first word two cycles after the request and each later word one cycle after the previous one.

A configuration input turns caching off, and each fetch then reads one word straight from memory. A supervisor-mode invalidate command clears every valid bit in one clock cycle. A user-mode invalidate command has no effect except to raise a privilege-fault pulse.

Top module: `modetag_icache`

## Requirements
- R1: A fetch that hits asserts `fetch_ready` in the same cycle as `fetch_req`, returns the cached word, and issues no memory request.
- R2: A miss drives `mem_req` high for exactly one cycle, with `mem_single` low and `mem_addr` equal to the physical address with its low 4 bits cleared. The words of the line are accepted in order of word offset 0 to 3. `fetch_ready` rises with the beat whose offset equals address bits [3:2]. With 2/1 memory timing this is 3 + offset cycles after the fetch is presented, counting the request cycle as 1.
- R3: A line becomes valid only once its fourth word is written. After that, fetches to any word of the line hit.
- R4: The user/supervisor bit is part of the tag compare. A fetch in one mode misses on a line filled in the other mode, and both copies can be resident together.
- R5: With `phys_mode` low, index and tag come from `fetch_vaddr`, so a remapped physical address still hits the old line. With `phys_mode` high, they come from `fetch_paddr`.
- R6: While `cfg_disable` is high, every fetch issues a one-word memory request (`mem_single` high, `mem_addr` equal to the word-aligned physical address) and returns that word. No line is allocated and no resident line is changed.
- R7: A supervisor invalidate (`inval_req` with `inval_super` high) clears all valid bits in a single cycle. Every later fetch misses until it is refilled.
- R8: A user invalidate (`inval_req` with `inval_super` low) leaves all lines intact. It makes `priv_fault` high for exactly the one cycle after the request.
- R9: A supervisor invalidate that arrives during a refill, including in the cycle of the final beat, aborts the fill and leaves that line invalid. The waiting fetch still receives correct data.
- R10: On a miss with both ways valid, the way not most recently used (by a hit or a completed fill) is replaced.
- R11: After reset, `fetch_ready`, `mem_req` and `priv_fault` are low and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_disable | input | 1 | 1: bypass the cache for every fetch |
| phys_mode | input | 1 | 1: tag with physical address; 0: tag with virtual address |
| fetch_req | input | 1 | Fetch request, held with its addresses until `fetch_ready` |
| fetch_super | input | 1 | Mode of the fetch: 1 supervisor, 0 user |
| fetch_vaddr | input | 32 | Virtual byte address of the fetch |
| fetch_paddr | input | 32 | Physical byte address of the fetch |
| fetch_ready | output | 1 | Fetched word is valid this cycle |
| fetch_data | output | 32 | Fetched instruction word |
| inval_req | input | 1 | Invalidate-all command, one-cycle pulse |
| inval_super | input | 1 | Mode of the invalidate issuer: 1 supervisor |
| priv_fault | output | 1 | One-cycle pulse after a user-mode invalidate |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_single | output | 1 | 1: one-word read; 0: four-word line burst |
| mem_addr | output | 32 | Physical byte address of the memory read |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The key collision is a supervisor invalidate landing in the same cycle as a refill beat, and in particular the final beat, which would otherwise set the line's valid bit. The bench forks a fetch against an invalidate pulse placed a fixed number of cycles after the observed memory request: once in the middle of the fill and once on the fourth beat. In both cases the scoreboard must see the correct critical word delivered, and a repeat fetch of the same line must raise a fresh memory request. A user-mode invalidate placed between hits is judged by the one-cycle fault pulse and by a later hit that issues no memory request.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_BYP  = 2'd2
    } ic_state_e;
endpackage

// File: rtl/icache_valid.sv
module icache_valid #(
    parameter int SETS = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_idx,
    output logic [1:0]              vld,
    output logic                    victim_lru,
    input  logic                    set_en,
    input  logic [$clog2(SETS)-1:0] set_idx,
    input  logic                    set_way,
    input  logic                    clr_all,
    input  logic                    touch_en,
    input  logic [$clog2(SETS)-1:0] touch_idx,
    input  logic                    touch_way
);
    typedef struct packed {
        logic [SETS-1:0][1:0] vbits;
        logic [SETS-1:0]      lru;
    } vstate_t;

    vstate_t vs_d, vs_q;

    always_comb begin
        vs_d = vs_q;
        if (touch_en) vs_d.lru[touch_idx] = ~touch_way;
        if (set_en)   vs_d.vbits[set_idx][set_way] = 1'b1;
        if (clr_all)  vs_d.vbits = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_q <= '0;
        else        vs_q <= vs_d;
    end

    assign vld        = vs_q.vbits[rd_idx];
    assign victim_lru = vs_q.lru[rd_idx];

    // R7: one cycle after a clear, no way reads back as valid
    a_r7_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (vld == 2'b00));
    // R9: the controller never completes a line in a clearing cycle
    a_r9_no_set_during_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !clr_all);
endmodule

// File: rtl/icache_store.sv
module icache_store #(
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WORDS  = 4,
    parameter int TAGM_W = 22
) (
    input  logic                      clk,
    input  logic [$clog2(SETS)-1:0]   rd_idx,
    input  logic [$clog2(WORDS)-1:0]  rd_word,
    output logic [1:0][TAGM_W-1:0]    rd_tag,
    output logic [1:0][DATA_W-1:0]    rd_data,
    input  logic                      wr_en,
    input  logic                      wr_way,
    input  logic [$clog2(SETS)-1:0]   wr_idx,
    input  logic [$clog2(WORDS)-1:0]  wr_word,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      tag_we,
    input  logic [TAGM_W-1:0]         tag_val
);
    logic [DATA_W-1:0] data_mem [2][SETS][WORDS];
    logic [TAGM_W-1:0] tag_mem  [2][SETS];

    always_ff @(posedge clk) begin
        if (wr_en)  data_mem[wr_way][wr_idx][wr_word] <= wr_data;
        if (tag_we) tag_mem[wr_way][wr_idx] <= tag_val;
    end

    for (genvar w = 0; w < 2; w++) begin : g_rd
        assign rd_tag[w]  = tag_mem[w][rd_idx];
        assign rd_data[w] = data_mem[w][rd_idx][rd_word];
    end
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WORDS  = 4,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int WOFF_W = $clog2(WORDS),
    localparam int BOFF_W = BYTE_W + WOFF_W,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - BOFF_W - IDX_W,
    localparam int TAGM_W = TAG_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_disable,
    input  logic                     phys_mode,
    input  logic                     fetch_req,
    input  logic                     fetch_super,
    input  logic [ADDR_W-1:0]        fetch_vaddr,
    input  logic [ADDR_W-1:0]        fetch_paddr,
    output logic                     fetch_ready,
    output logic [DATA_W-1:0]        fetch_data,
    input  logic                     inval_req,
    input  logic                     inval_super,
    output logic                     priv_fault,
    output logic                     mem_req,
    output logic                     mem_single,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [IDX_W-1:0]         rd_idx,
    output logic [WOFF_W-1:0]        rd_word,
    input  logic [1:0][TAGM_W-1:0]   rd_tag,
    input  logic [1:0][DATA_W-1:0]   rd_data,
    input  logic [1:0]               vld,
    input  logic                     victim_lru,
    output logic                     wr_en,
    output logic [WOFF_W-1:0]        wr_word,
    output logic                     tag_we,
    output logic [TAGM_W-1:0]        tag_val,
    output logic                     line_way,
    output logic [IDX_W-1:0]         line_idx,
    output logic                     set_en,
    output logic                     clr_all,
    output logic                     touch_en,
    output logic [IDX_W-1:0]         touch_idx,
    output logic                     touch_way
);
    typedef struct packed {
        ic_state_e          st;
        logic [WOFF_W-1:0]  beat;
        logic [WOFF_W-1:0]  crit;
        logic               way;
        logic [IDX_W-1:0]   idx;
        logic [TAGM_W-1:0]  tag;
        logic               abort;
        logic               fault;
    } ctl_t;

    ctl_t cs_d, cs_q;

    logic [ADDR_W-1:0] tag_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [WOFF_W-1:0] lk_word;
    logic [TAGM_W-1:0] lk_tag;
    logic [1:0]        way_hit;
    logic              hit, hit_way, victim;
    logic              unused_bits;

    assign tag_addr = phys_mode ? fetch_paddr : fetch_vaddr;
    assign lk_idx   = tag_addr[BOFF_W +: IDX_W];
    assign lk_word  = tag_addr[BYTE_W +: WOFF_W];
    assign lk_tag   = {fetch_super, tag_addr[ADDR_W-1 -: TAG_W]};
    assign unused_bits = ^{tag_addr[BYTE_W-1:0], fetch_paddr[BYTE_W-1:0]};

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign way_hit[w] = vld[w] && (rd_tag[w] == lk_tag);
    end
    assign hit     = |way_hit;
    assign hit_way = way_hit[1];
    assign victim  = !vld[0] ? 1'b0 : (!vld[1] ? 1'b1 : victim_lru);

    assign rd_idx     = lk_idx;
    assign rd_word    = lk_word;
    assign wr_word    = cs_q.beat;
    assign tag_val    = cs_q.tag;
    assign line_way   = cs_q.way;
    assign line_idx   = cs_q.idx;
    assign priv_fault = cs_q.fault;

    always_comb begin
        cs_d        = cs_q;
        fetch_ready = 1'b0;
        fetch_data  = '0;
        mem_req     = 1'b0;
        mem_single  = 1'b0;
        mem_addr    = '0;
        wr_en       = 1'b0;
        tag_we      = 1'b0;
        set_en      = 1'b0;
        touch_en    = 1'b0;
        touch_idx   = cs_q.idx;
        touch_way   = cs_q.way;

        clr_all    = inval_req && inval_super;
        cs_d.fault = inval_req && !inval_super;
        if (clr_all && cs_q.st == ST_FILL) cs_d.abort = 1'b1;

        unique case (cs_q.st)
            ST_IDLE: begin
                if (fetch_req) begin
                    if (cfg_disable) begin
                        mem_req    = 1'b1;
                        mem_single = 1'b1;
                        mem_addr   = {fetch_paddr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
                        cs_d.st    = ST_BYP;
                    end else if (hit) begin
                        fetch_ready = 1'b1;
                        fetch_data  = rd_data[hit_way];
                        touch_en    = 1'b1;
                        touch_idx   = lk_idx;
                        touch_way   = hit_way;
                    end else begin
                        mem_req    = 1'b1;
                        mem_addr   = {fetch_paddr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
                        cs_d.st    = ST_FILL;
                        cs_d.beat  = '0;
                        cs_d.crit  = lk_word;
                        cs_d.way   = victim;
                        cs_d.idx   = lk_idx;
                        cs_d.tag   = lk_tag;
                        cs_d.abort = 1'b0;
                    end
                end
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    wr_en     = 1'b1;
                    cs_d.beat = cs_q.beat + 1'b1;
                    if (cs_q.beat == cs_q.crit) begin
                        fetch_ready = 1'b1;
                        fetch_data  = mem_rdata;
                    end
                    if (cs_q.beat == WOFF_W'(WORDS - 1)) begin
                        cs_d.st = ST_IDLE;
                        if (!cs_q.abort && !clr_all) begin
                            set_en   = 1'b1;
                            tag_we   = 1'b1;
                            touch_en = 1'b1;
                        end
                    end
                end
            end
            ST_BYP: begin
                if (mem_rvalid) begin
                    fetch_ready = 1'b1;
                    fetch_data  = mem_rdata;
                    cs_d.st     = ST_IDLE;
                end
            end
            default: cs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '{st: ST_IDLE, default: '0};
        else        cs_q <= cs_d;
    end

    // R8: a fault pulse only ever follows a user-mode invalidate
    a_r8_fault_after_user_inval: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> $past(inval_req && !inval_super));
    // R2: a memory request lasts exactly one cycle
    a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R6: with caching off, every memory read is one word
    a_r6_bypass_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cfg_disable) |-> mem_single);
    // R1: data is handed out only to a pending fetch
    a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> fetch_req);
endmodule

// File: rtl/modetag_icache.sv
module modetag_icache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_disable,
    input  logic              phys_mode,
    input  logic              fetch_req,
    input  logic              fetch_super,
    input  logic [ADDR_W-1:0] fetch_vaddr,
    input  logic [ADDR_W-1:0] fetch_paddr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    input  logic              inval_req,
    input  logic              inval_super,
    output logic              priv_fault,
    output logic              mem_req,
    output logic              mem_single,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WOFF_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAGM_W = ADDR_W - BYTE_W - WOFF_W - IDX_W + 1;

    logic [IDX_W-1:0]        rd_idx, line_idx, touch_idx;
    logic [WOFF_W-1:0]       rd_word, wr_word;
    logic [1:0][TAGM_W-1:0]  rd_tag;
    logic [1:0][DATA_W-1:0]  rd_data;
    logic [1:0]              vld;
    logic                    victim_lru, wr_en, tag_we, line_way;
    logic                    set_en, clr_all, touch_en, touch_way;
    logic [TAGM_W-1:0]       tag_val;

    icache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .phys_mode(phys_mode),
        .fetch_req(fetch_req), .fetch_super(fetch_super),
        .fetch_vaddr(fetch_vaddr), .fetch_paddr(fetch_paddr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .inval_req(inval_req), .inval_super(inval_super), .priv_fault(priv_fault),
        .mem_req(mem_req), .mem_single(mem_single), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rd_idx(rd_idx), .rd_word(rd_word), .rd_tag(rd_tag), .rd_data(rd_data),
        .vld(vld), .victim_lru(victim_lru),
        .wr_en(wr_en), .wr_word(wr_word), .tag_we(tag_we), .tag_val(tag_val),
        .line_way(line_way), .line_idx(line_idx), .set_en(set_en), .clr_all(clr_all),
        .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way)
    );

    icache_store #(.DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS), .TAGM_W(TAGM_W)) u_store (
        .clk(clk), .rd_idx(rd_idx), .rd_word(rd_word), .rd_tag(rd_tag), .rd_data(rd_data),
        .wr_en(wr_en), .wr_way(line_way), .wr_idx(line_idx), .wr_word(wr_word),
        .wr_data(mem_rdata), .tag_we(tag_we), .tag_val(tag_val)
    );

    icache_valid #(.SETS(SETS)) u_valid (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .vld(vld), .victim_lru(victim_lru),
        .set_en(set_en), .set_idx(line_idx), .set_way(line_way), .clr_all(clr_all),
        .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way)
    );
endmodule

// File: tb/modetag_icache_tb.sv
module modetag_icache_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_disable, phys_mode, fetch_req, fetch_super;
    logic [31:0] fetch_vaddr, fetch_paddr, fetch_data, mem_addr, mem_rdata;
    logic        fetch_ready, inval_req, inval_super, priv_fault;
    logic        mem_req, mem_single, mem_rvalid;

    int          total = 0, bad = 0, req_cnt = 0, lat = 0;
    logic [31:0] last_addr, mbase, mon_e;
    logic        last_single;
    int          mnb;
    logic [31:0] exp_q[$];
    string       cur_req = "R1";

    always #5 clk = ~clk;

    modetag_icache u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .phys_mode(phys_mode),
        .fetch_req(fetch_req), .fetch_super(fetch_super),
        .fetch_vaddr(fetch_vaddr), .fetch_paddr(fetch_paddr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .inval_req(inval_req), .inval_super(inval_super), .priv_fault(priv_fault),
        .mem_req(mem_req), .mem_single(mem_single), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: 2/1 timing, words of a line in offset order
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                req_cnt++;
                last_addr   = mem_addr;
                last_single = mem_single;
                mbase       = mem_addr;
                mnb         = mem_single ? 1 : 4;
                @(posedge clk); #1;
                @(posedge clk); #1;
                for (int i = 0; i < mnb; i++) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = memf(mbase + 32'(i) * 4);
                    @(posedge clk); #1;
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && fetch_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected fetch_ready", fetch_data, 32'h0);
            end else begin
                mon_e = exp_q.pop_front();
                chk(fetch_data === mon_e, {cur_req, " fetch data"}, fetch_data, mon_e);
            end
        end
    end

    task automatic fetch_va(input logic [31:0] va, input logic [31:0] pa, input logic sup,
                            input logic [31:0] exp, input bit miss, input string req);
        int n0;
        @(posedge clk); #1;
        fetch_vaddr = va;
        fetch_paddr = pa;
        fetch_super = sup;
        fetch_req   = 1'b1;
        cur_req     = req;
        exp_q.push_back(exp);
        n0  = req_cnt;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (fetch_ready !== 1'b1);
        @(posedge clk); #1;
        fetch_req = 1'b0;
        chk((req_cnt - n0) == (miss ? 1 : 0), {req, " memory request count"},
            32'(req_cnt - n0), miss ? 32'd1 : 32'd0);
    endtask

    task automatic fetch(input logic [31:0] pa, input logic sup, input bit miss, input string req);
        fetch_va(pa, pa, sup, memf(pa), miss, req);
    endtask

    task automatic inval(input logic sup);
        @(posedge clk); #1;
        inval_req   = 1'b1;
        inval_super = sup;
        @(posedge clk); #1;
        inval_req   = 1'b0;
    endtask

    task automatic abort_case(input logic [31:0] pa, input int k, input string req);
        fork
            fetch(pa, 1'b1, 1'b1, req);
            begin
                @(negedge clk iff mem_req);
                repeat (k) @(posedge clk);
                #1;
                inval_req   = 1'b1;
                inval_super = 1'b1;
                @(posedge clk); #1;
                inval_req   = 1'b0;
            end
        join
        fetch(pa, 1'b1, 1'b1, {req, " refetch after abort"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_disable = 1'b0; phys_mode = 1'b1;
        fetch_req = 1'b0; fetch_super = 1'b0; fetch_vaddr = '0; fetch_paddr = '0;
        inval_req = 1'b0; inval_super = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(fetch_ready == 1'b0, "R11 fetch_ready after reset", 32'(fetch_ready), 0);
        chk(mem_req == 1'b0, "R11 mem_req after reset", 32'(mem_req), 0);
        chk(priv_fault == 1'b0, "R11 priv_fault after reset", 32'(priv_fault), 0);

        // R2 miss on word offset 2, then R3 line hits
        fetch(32'h108, 1'b1, 1'b1, "R2 miss");
        chk(last_addr == 32'h100, "R2 line address", last_addr, 32'h100);
        chk(last_single == 1'b0, "R2 burst request", 32'(last_single), 0);
        chk(lat == 5, "R2 critical word latency", 32'(lat), 32'd5);
        fetch(32'h100, 1'b1, 1'b0, "R3 hit word0");
        fetch(32'h104, 1'b1, 1'b0, "R3 hit word1");
        fetch(32'h10C, 1'b1, 1'b0, "R3 hit word3");
        chk(lat == 1, "R1 hit same cycle", 32'(lat), 32'd1);

        // R4 mode bit in the tag
        fetch(32'h104, 1'b0, 1'b1, "R4 user miss on supervisor line");
        fetch(32'h104, 1'b1, 1'b0, "R4 supervisor copy still hits");
        fetch(32'h104, 1'b0, 1'b0, "R4 user copy hits");

        // R10 LRU: supervisor way is least recently used
        fetch(32'h900, 1'b1, 1'b1, "R10 third tag miss");
        fetch(32'h100, 1'b0, 1'b0, "R10 recent user line kept");
        fetch(32'h100, 1'b1, 1'b1, "R10 older supervisor line evicted");

        // R6 bypass
        cfg_disable = 1'b1;
        fetch(32'h104, 1'b0, 1'b1, "R6 bypass of cached line");
        chk(last_single == 1'b1, "R6 single word request", 32'(last_single), 1);
        chk(last_addr == 32'h104, "R6 word address", last_addr, 32'h104);
        fetch(32'h2000, 1'b1, 1'b1, "R6 bypass uncached");
        cfg_disable = 1'b0;
        fetch(32'h2000, 1'b1, 1'b1, "R6 bypass did not allocate");
        fetch(32'h104, 1'b0, 1'b0, "R6 resident line untouched");

        // R8 user invalidate ignored
        inval(1'b0);
        @(negedge clk);
        chk(priv_fault == 1'b1, "R8 fault pulse", 32'(priv_fault), 1);
        @(negedge clk);
        chk(priv_fault == 1'b0, "R8 fault one cycle", 32'(priv_fault), 0);
        fetch(32'h104, 1'b0, 1'b0, "R8 line survives user invalidate");

        // R7 supervisor invalidate
        inval(1'b1);
        @(negedge clk);
        chk(priv_fault == 1'b0, "R7 no fault for supervisor", 32'(priv_fault), 0);
        fetch(32'h104, 1'b0, 1'b1, "R7 miss after clear");
        fetch(32'h2000, 1'b1, 1'b1, "R7 second line cleared");

        // R9 invalidate during refill: mid-fill and on the final beat
        abort_case(32'h3000, 1, "R9 mid-fill");
        abort_case(32'h4008, 5, "R9 final beat");

        // R5 virtual versus physical tagging
        phys_mode = 1'b0;
        fetch_va(32'h5010, 32'h8010, 1'b1, memf(32'h8010), 1'b1, "R5 virtual miss");
        fetch_va(32'h5010, 32'h9010, 1'b1, memf(32'h8010), 1'b0, "R5 virtual hit after remap");
        phys_mode = 1'b1;
        fetch_va(32'h5010, 32'h9010, 1'b1, memf(32'h9010), 1'b1, "R5 physical miss");
        fetch_va(32'h7010, 32'h9010, 1'b1, memf(32'h9010), 1'b0, "R5 physical hit");

        repeat (8) @(posedge clk);
        chk(exp_q.size() == 0, "R1 all expected words delivered", 32'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule